// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block sits behind the bus-cycle latch of a 16-bit parallel flash and turns the stream of captured write cycles into operation requests. Every command is guarded by an unlock pair of writes. After the pair, a third write either arms a word program, arms an erase, or switches the read path into an identification or query mode. An erase needs a second unlock pair before the final write that names its scope: sector, block or whole array.

Each accepted request is a one-cycle start pulse. With it come the target word address and, for a program, the data word. The address is cut to the sector or block boundary for the two partial erases. Two mode flags tell the read path whether to return identification words or query-table words instead of array data. A busy input from the operation engine freezes the interpreter, so that no write has any effect until the operation finishes. A write that breaks a sequence drops the interpreter back to plain read mode.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset no start pulse is active, both mode flags are 0 and the interpreter waits for the first unlock write.
- R2: The writes AAh@5555h, 55h@2AAAh and A0h@5555h, followed by any write (A, D), raise `prog_start` for one cycle, one clock after that last write, with `tgt_addr` = A and `tgt_data` = D (all 16 bits).
- R3: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh, followed by 30h at any address A, raise `sect_erase_start`. `tgt_addr` is A with bits below SECT_LSB (default 11) cleared.
- R4: The same five-write prefix followed by 50h at address A raises `blk_erase_start`. `tgt_addr` is A with bits below BLK_LSB (default 15) cleared.
- R5: The same prefix followed by 10h at 5555h raises `chip_erase_start` with `tgt_addr` = 0. A final 10h at any other address starts nothing and aborts.
- R6: The writes AAh@5555h and 55h@2AAAh, followed by 90h@5555h, set `id_mode`. Followed instead by 98h@5555h, they set `cfi_mode`. The two flags are never 1 together.
- R7: F0h written to any address while no sequence is in progress clears both mode flags. The three-write form ending in F0h@5555h has the same effect.
- R8: A write that does not match the expected cycle returns the interpreter to its waiting state, clears both mode flags and produces no start pulse.
- R9: While `busy` is 1, writes are ignored. This includes the exit write and writes in the middle of a sequence. No pulse occurs, the mode flags hold, and a partly entered sequence continues once `busy` falls.
- R10: Command matching looks only at address bits [14:0] and data bits [7:0]. The upper address bits and the upper data byte do not affect decoding.
- R11: A sequence may begin while a mode flag is set. The flag stays set through the unlock writes. Each start pulse returns the interpreter to read mode with both flags 0.
- R12: At most one start pulse is active in any cycle, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | One latched bus write cycle is present |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Data word of the write |
| busy | input | 1 | Operation engine is programming or erasing |
| prog_start | output | 1 | Word program request pulse |
| sect_erase_start | output | 1 | Sector erase request pulse |
| blk_erase_start | output | 1 | Block erase request pulse |
| chip_erase_start | output | 1 | Whole-array erase request pulse |
| tgt_addr | output | ADDR_W | Target address for the request |
| tgt_data | output | DATA_W | Program data word |
| id_mode | output | 1 | Identification read mode active |
| cfi_mode | output | 1 | Query-table read mode active |

## Verification
The hardest situation to reach is a sequence that `busy` interrupts halfway. The interpreter must keep its position, ignore the writes made during `busy`, and then finish the command correctly. The stimulus enters two unlock writes, raises `busy`, sends a write that would abort the sequence if it were accepted, drops `busy`, and completes a program. A program pulse at that point shows that the position was kept. The same test also starts from identification mode, so the one run covers both the flag surviving the unlock writes and the flag clearing on the start pulse.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int CMD_AW = 15;
  localparam logic [CMD_AW-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [CMD_AW-1:0] KEY_ADDR_B = 15'h2AAA;

  localparam int OP_PROG = 0;
  localparam int OP_SECT = 1;
  localparam int OP_BLK  = 2;
  localparam int OP_CHIP = 3;
  localparam int OP_N    = 4;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PGM_ARM, SQ_ERS_ARM, SQ_ERS_UNL1, SQ_ERS_UNL2
  } seq_state_e;

  typedef enum logic [1:0] {MD_READ, MD_ID, MD_CFI} mode_e;

  typedef struct packed {
    logic at_a;
    logic at_b;
    logic d_aa;
    logic d_55;
    logic d_a0;
    logic d_80;
    logic d_90;
    logic d_98;
    logic d_30;
    logic d_50;
    logic d_10;
  } wr_class_t;
endpackage

// File: rtl/fcd_match.sv
module fcd_match
  import flash_cmd_pkg::*;
(
  input  logic [CMD_AW-1:0] addr_lo,
  input  logic [7:0]        data_lo,
  output wr_class_t         cls
);
  always_comb begin
    cls.at_a = (addr_lo == KEY_ADDR_A);
    cls.at_b = (addr_lo == KEY_ADDR_B);
    cls.d_aa = (data_lo == 8'hAA);
    cls.d_55 = (data_lo == 8'h55);
    cls.d_a0 = (data_lo == 8'hA0);
    cls.d_80 = (data_lo == 8'h80);
    cls.d_90 = (data_lo == 8'h90);
    cls.d_98 = (data_lo == 8'h98);
    cls.d_30 = (data_lo == 8'h30);
    cls.d_50 = (data_lo == 8'h50);
    cls.d_10 = (data_lo == 8'h10);
  end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import flash_cmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            acc,
  input  wr_class_t       cls,
  output logic [OP_N-1:0] fire,
  output mode_e           mode
);
  seq_state_e state, nxt_state;
  mode_e      nxt_mode;

  always_comb begin
    nxt_state = state;
    nxt_mode  = mode;
    fire      = '0;
    if (acc) begin
      nxt_state = SQ_IDLE;
      case (state)
        SQ_IDLE:
          if (cls.at_a && cls.d_aa) nxt_state = SQ_UNL1;
          else nxt_mode = MD_READ;
        SQ_UNL1:
          if (cls.at_b && cls.d_55) nxt_state = SQ_UNL2;
          else nxt_mode = MD_READ;
        SQ_UNL2:
          if (cls.at_a && cls.d_a0)      nxt_state = SQ_PGM_ARM;
          else if (cls.at_a && cls.d_80) nxt_state = SQ_ERS_ARM;
          else if (cls.at_a && cls.d_90) nxt_mode  = MD_ID;
          else if (cls.at_a && cls.d_98) nxt_mode  = MD_CFI;
          else nxt_mode = MD_READ;
        SQ_PGM_ARM: begin
          fire[OP_PROG] = 1'b1;
          nxt_mode = MD_READ;
        end
        SQ_ERS_ARM:
          if (cls.at_a && cls.d_aa) nxt_state = SQ_ERS_UNL1;
          else nxt_mode = MD_READ;
        SQ_ERS_UNL1:
          if (cls.at_b && cls.d_55) nxt_state = SQ_ERS_UNL2;
          else nxt_mode = MD_READ;
        SQ_ERS_UNL2: begin
          nxt_mode = MD_READ;
          if (cls.d_30)                 fire[OP_SECT] = 1'b1;
          else if (cls.d_50)            fire[OP_BLK]  = 1'b1;
          else if (cls.d_10 && cls.at_a) fire[OP_CHIP] = 1'b1;
        end
        default: nxt_mode = MD_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      mode  <= MD_READ;
    end else begin
      state <= nxt_state;
      mode  <= nxt_mode;
    end
  end

  // R11
  idle_after_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (|fire) |=> (state == SQ_IDLE && mode == MD_READ));
endmodule

// File: rtl/fcd_launch.sv
module fcd_launch
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_N-1:0]   fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [OP_N-1:0]   pulses,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_data
);
  logic [ADDR_W-1:0] sect_mask, blk_mask, nxt_addr;

  for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
    assign sect_mask[b] = (b >= SECT_LSB);
    assign blk_mask[b]  = (b >= BLK_LSB);
  end

  always_comb begin
    nxt_addr = wr_addr;
    if (fire[OP_SECT])      nxt_addr = wr_addr & sect_mask;
    else if (fire[OP_BLK])  nxt_addr = wr_addr & blk_mask;
    else if (fire[OP_CHIP]) nxt_addr = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulses   <= '0;
      tgt_addr <= '0;
      tgt_data <= '0;
    end else begin
      pulses <= fire;
      if (|fire) begin
        tgt_addr <= nxt_addr;
        tgt_data <= wr_data;
      end
    end
  end

  // R12
  one_pulse_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(pulses));
  // R12
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    (|pulses) |=> !(|pulses));
  // R5
  chip_addr_chk: assert property (@(posedge clk) disable iff (rst)
    pulses[OP_CHIP] |-> (tgt_addr == '0));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              prog_start,
  output logic              sect_erase_start,
  output logic              blk_erase_start,
  output logic              chip_erase_start,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_data,
  output logic              id_mode,
  output logic              cfi_mode
);
  wr_class_t       cls;
  logic [OP_N-1:0] fire, pulses;
  mode_e           mode;
  logic            acc;

  assign acc = wr_valid && !busy;

  fcd_match u_match (
    .addr_lo(wr_addr[CMD_AW-1:0]),
    .data_lo(wr_data[7:0]),
    .cls    (cls)
  );

  fcd_seq u_seq (
    .clk (clk),
    .rst (rst),
    .acc (acc),
    .cls (cls),
    .fire(fire),
    .mode(mode)
  );

  fcd_launch #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB)
  ) u_launch (
    .clk     (clk),
    .rst     (rst),
    .fire    (fire),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pulses  (pulses),
    .tgt_addr(tgt_addr),
    .tgt_data(tgt_data)
  );

  assign prog_start       = pulses[OP_PROG];
  assign sect_erase_start = pulses[OP_SECT];
  assign blk_erase_start  = pulses[OP_BLK];
  assign chip_erase_start = pulses[OP_CHIP];
  assign id_mode          = (mode == MD_ID);
  assign cfi_mode         = (mode == MD_CFI);

  // R9
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !(prog_start || sect_erase_start || blk_erase_start || chip_erase_start));
  // R9
  busy_mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(id_mode) && $stable(cfi_mode)));
  // R6
  mode_excl_chk: assert property (@(posedge clk) disable iff (rst) !(id_mode && cfi_mode));
endmodule

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
  localparam int AW = 19;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic busy = 1'b0;
  logic prog_start, sect_erase_start, blk_erase_start, chip_erase_start;
  logic [AW-1:0] tgt_addr;
  logic [DW-1:0] tgt_data;
  logic id_mode, cfi_mode;

  always #2.5 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .prog_start(prog_start), .sect_erase_start(sect_erase_start),
    .blk_erase_start(blk_erase_start), .chip_erase_start(chip_erase_start),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data), .id_mode(id_mode), .cfi_mode(cfi_mode)
  );

  typedef struct {
    logic [3:0]    p;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          id;
    logic          cfi;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;
  logic cur_id = 0, cur_cfi = 0;

  // monitor: compare outputs against the queued expectations
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      logic [3:0] got;
      e = q.pop_front();
      got = {chip_erase_start, blk_erase_start, sect_erase_start, prog_start};
      n_tests++;
      if (got !== e.p || id_mode !== e.id || cfi_mode !== e.cfi) begin
        n_fail++;
        $display("FAIL %s: pulses/id/cfi = %b/%b/%b expected %b/%b/%b",
                 e.tag, got, id_mode, cfi_mode, e.p, e.id, e.cfi);
      end else if (e.p != 0 && (tgt_addr !== e.a || tgt_data !== e.d)) begin
        n_fail++;
        $display("FAIL %s: addr/data = %h/%h expected %h/%h",
                 e.tag, tgt_addr, tgt_data, e.a, e.d);
      end
    end
  end

  task automatic push(input logic [3:0] p, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input string tag);
    exp_t e;
    e.p = p; e.a = a; e.d = d; e.id = cur_id; e.cfi = cur_cfi; e.tag = tag;
    q.push_back(e);
  endtask

  // one write cycle; expectation taken from cur_id/cur_cfi after the write
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] p,
                    input logic [AW-1:0] ea, input string tag);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    push(p, ea, d, tag);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic gap(input string tag);
    @(posedge clk);
    push(4'b0000, '0, '0, tag);
    @(negedge clk);
  endtask

  task automatic unlock(input string tag);
    wr(19'h0_5555, 16'h00AA, 4'b0, '0, tag);
    wr(19'h0_2AAA, 16'h0055, 4'b0, '0, tag);
  endtask

  task automatic erase_prefix(input string tag);
    unlock(tag);
    wr(19'h0_5555, 16'h0080, 4'b0, '0, tag);
    unlock(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    gap("R1 reset state");

    // R2 word program
    unlock("R2 unlock");
    wr(19'h0_5555, 16'h00A0, 4'b0, '0, "R2 arm");
    wr(19'h4_1234, 16'hBEEF, 4'b0001, 19'h4_1234, "R2 program pulse");
    gap("R12 pulse lasts one cycle");

    // R3 sector erase
    erase_prefix("R3 prefix");
    wr(19'h5_3ABC, 16'h0030, 4'b0010, 19'h5_3800, "R3 sector erase");
    // R4 block erase
    erase_prefix("R4 prefix");
    wr(19'h5_3ABC, 16'h0050, 4'b0100, 19'h5_0000, "R4 block erase");
    // R5 chip erase and wrong-address abort
    erase_prefix("R5 prefix");
    wr(19'h0_5555, 16'h0010, 4'b1000, 19'h0, "R5 chip erase");
    erase_prefix("R5 prefix bad");
    wr(19'h0_1234, 16'h0010, 4'b0000, '0, "R5 chip erase wrong address");

    // R6 / R7 modes and exits
    unlock("R6 unlock");
    cur_id = 1;
    wr(19'h0_5555, 16'h0090, 4'b0, '0, "R6 id entry");
    cur_id = 0;
    wr(19'h7_0123, 16'h00F0, 4'b0, '0, "R7 short exit");
    unlock("R6 unlock cfi");
    cur_cfi = 1;
    wr(19'h0_5555, 16'h0098, 4'b0, '0, "R6 cfi entry");
    unlock("R7 long exit unlock");
    cur_cfi = 0;
    wr(19'h0_5555, 16'h00F0, 4'b0, '0, "R7 long exit");

    // R8 abort
    wr(19'h0_5555, 16'h00AA, 4'b0, '0, "R8 first");
    wr(19'h0_2AAB, 16'h0055, 4'b0, '0, "R8 wrong address");
    wr(19'h0_5555, 16'h00A0, 4'b0, '0, "R8 not armed");
    wr(19'h0_0100, 16'h1111, 4'b0, '0, "R8 no program after abort");
    unlock("R8 id unlock");
    cur_id = 1;
    wr(19'h0_5555, 16'h0090, 4'b0, '0, "R8 id entry");
    cur_id = 0;
    wr(19'h0_0000, 16'h0012, 4'b0, '0, "R8 garbage clears mode");

    // R9 busy: exit ignored, whole program ignored
    unlock("R9 id unlock");
    cur_id = 1;
    wr(19'h0_5555, 16'h0090, 4'b0, '0, "R9 id entry");
    @(negedge clk); busy = 1'b1;
    wr(19'h0_0000, 16'h00F0, 4'b0, '0, "R9 exit ignored while busy");
    unlock("R9 busy unlock");
    wr(19'h0_5555, 16'h00A0, 4'b0, '0, "R9 busy arm");
    wr(19'h0_0777, 16'h7777, 4'b0, '0, "R9 busy program ignored");
    @(negedge clk); busy = 1'b0;
    // R9 / R11 sequence position held across busy, started in id mode
    unlock("R11 unlock in id mode");
    @(negedge clk); busy = 1'b1;
    wr(19'h0_0000, 16'h0030, 4'b0, '0, "R9 mid-sequence write ignored");
    @(negedge clk); busy = 1'b0;
    wr(19'h0_5555, 16'h00A0, 4'b0, '0, "R9 arm after busy");
    cur_id = 0;
    wr(19'h2_0002, 16'h1234, 4'b0001, 19'h2_0002, "R11 pulse clears id");

    // R10 upper address bits and upper data byte ignored
    wr(19'h7_5555, 16'h12AA, 4'b0, '0, "R10 first");
    wr(19'h1_2AAA, 16'hFF55, 4'b0, '0, "R10 second");
    wr(19'h3_5555, 16'h00A0, 4'b0, '0, "R10 arm");
    wr(19'h0_0040, 16'hCAFE, 4'b0001, 19'h0_0040, "R10 program pulse");

    // R11 erase started from cfi mode
    unlock("R11 cfi unlock");
    cur_cfi = 1;
    wr(19'h0_5555, 16'h0098, 4'b0, '0, "R11 cfi entry");
    erase_prefix("R11 prefix keeps cfi");
    cur_cfi = 0;
    wr(19'h6_7FFF, 16'hAB30, 4'b0010, 19'h6_7800, "R11 sector erase clears cfi");
    gap("R12 after erase");

    repeat (3) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule